// File: doc/BRIEF.md
# Three-Lane Serial-to-Parallel Frame Receiver

This block turns three serial data lanes into one 21-bit parallel word per frame period. It runs on a bit-rate clock at seven times the frame rate. That clock, and a one-cycle frame marker aligned to the first bit slot of each frame, come from clock recovery outside the block. Every lane is sampled once per bit slot. After seven slots the three 7-bit groups are joined into one word, and that word reaches the output two frame periods after its marker. A strobe output runs at the frame rate and rises while the data is stable, so a downstream register can capture the word on that rising edge.

An active-low power-down input forces the word and the strobe low. After power-down is released, nothing appears until a whole new frame has been collected. If the frame marker stops for a configurable number of bit-clock cycles, the block treats the forwarded clock as absent. It then freezes the last word and drives the strobe high until a complete frame arrives again. Lanes that idle high while markers keep arriving simply produce an all-ones word. The word map, slot order and loss window are parameters. The power-down input is synchronous to the bit clock.

Top module: `tl_deser`

## Requirements
- R1: Output bit `L*7+k` (lane L = 0..2, slot k = 0..6) is the value of `ser_in[L]` sampled at the k-th bit-clock edge of the frame. Slot 0 is the edge that samples `frame_mark` high.
- R2: Call the edge that samples `frame_mark` high edge e. A frame's word appears on `data_out` right after edge e+13, which is two frame periods later. Up to that edge `data_out` still holds the previous word. This holds for every frame when frames follow each other back to back.
- R3: Once a word has been shown, `strobe_out` falls on the edge that updates `data_out` and stays low for 3 bit-clock cycles. It is then high for 4 cycles, giving a 7-cycle period, and it never rises on an edge that changes `data_out`.
- R4: While `pwr_dn_n` is sampled low, `data_out` and `strobe_out` are 0 from the following edge on.
- R5: After `pwr_dn_n` returns high, `data_out` and `strobe_out` stay 0 until the first frame whose marker is sampled after the release has been collected. That frame then appears with the R2 latency. A frame whose marker came during power-down is dropped.
- R6: With markers present and all lanes held high, the word is all ones (0x1FFFFF).
- R7: After `LOSS_CYCLES` consecutive edges without a marker, `strobe_out` goes to 1 from that edge on and `data_out` keeps the last word.
- R8: In the lost state, the first complete frame after markers resume leaves that state. Its word appears with the R2 latency. `strobe_out` stays 1 until that edge and is 0 just after it.
- R9: After reset, `data_out` is 0 and `strobe_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, seven times the frame rate |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_n | input | 1 | Active-low power-down, synchronous to clk |
| frame_mark | input | 1 | High for one cycle in bit slot 0 of each frame |
| ser_in | input | 3 | One serial bit per lane per cycle |
| data_out | output | 21 | Registered parallel word |
| strobe_out | output | 1 | Frame-rate strobe, rising edge marks valid data |

## Verification
In back-to-back operation, the edge that collects the last bit of one frame is also the edge that loads the previous frame into `data_out`. The bench streams walking-one and random words with no gaps, so these two events always fall on the same edge. Each word is checked on the edge it must appear and on the edge just before it. Leaving the lost state also coincides with an output load. This is provoked by stopping the markers, resuming them with one frame, and checking that the strobe is still high one cycle before the new word and low exactly when the new word appears.

// File: rtl/tl_deser_pkg.sv
package tl_deser_pkg;
  // Per-cycle events of the slot sequencer.
  typedef struct packed {
    logic take;  // sample the lanes this cycle
    logic done;  // this cycle holds the last slot of a frame
  } slot_ev_t;
endpackage

// File: rtl/tl_slot_ctl.sv
module tl_slot_ctl
  import tl_deser_pkg::*;
#(
  parameter int BITS = 7
) (
  input  logic     clk,
  input  logic     clr,
  input  logic     mark,
  output slot_ev_t ev
);
  localparam int SW = $clog2(BITS + 1);
  localparam logic [SW-1:0] IDLE = SW'(BITS);

  logic [SW-1:0] nxt_q;
  logic [SW-1:0] cur;

  // A marker always restarts at slot 0; otherwise continue or stay idle.
  always_comb begin
    cur     = mark ? '0 : nxt_q;
    ev.take = (cur < IDLE);
    ev.done = (cur == SW'(BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (clr)          nxt_q <= IDLE;
    else if (ev.take) nxt_q <= cur + SW'(1);
    else              nxt_q <= IDLE;
  end
endmodule

// File: rtl/tl_lane_cap.sv
module tl_lane_cap #(
  parameter int BITS = 7
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            take,
  input  logic            ser,
  output logic [BITS-1:0] nxt
);
  logic [BITS-1:0] sh_q;

  // The newest bit enters at the top, so the first slot ends at bit 0.
  assign nxt = {ser, sh_q[BITS-1:1]};

  always_ff @(posedge clk) begin
    if (clr)       sh_q <= '0;
    else if (take) sh_q <= nxt;
  end
endmodule

// File: rtl/tl_clk_watch.sv
module tl_clk_watch #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic clr,
  input  logic mark,
  output logic loss_set
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign loss_set = !mark && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (clr || mark)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/tl_deser.sv
module tl_deser
  import tl_deser_pkg::*;
#(
  parameter int LANES       = 3,
  parameter int BITS        = 7,
  parameter int LOSS_CYCLES = 20   // must exceed 2*BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pwr_dn_n,
  input  logic                  frame_mark,
  input  logic [LANES-1:0]      ser_in,
  output logic [LANES*BITS-1:0] data_out,
  output logic                  strobe_out
);
  localparam int WORD = LANES * BITS;
  localparam int TW   = $clog2(BITS + 1);
  localparam int LOW  = BITS / 2;

  logic            clr;
  slot_ev_t        ev;
  logic [WORD-1:0] word_nxt;
  logic [WORD-1:0] cap_q;
  logic [TW-1:0]   tmr_q;
  logic [TW-1:0]   ph_q;
  logic [TW-1:0]   ph_n;
  logic            load;
  logic            loss_set;
  logic            hold_q;
  logic            hold_n;
  logic            live_q;

  assign clr = rst || !pwr_dn_n;

  tl_slot_ctl #(.BITS(BITS)) u_slot (
    .clk (clk),
    .clr (clr),
    .mark(frame_mark),
    .ev  (ev)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tl_lane_cap #(.BITS(BITS)) u_cap (
      .clk (clk),
      .clr (clr),
      .take(ev.take),
      .ser (ser_in[l]),
      .nxt (word_nxt[l*BITS +: BITS])
    );
  end

  tl_clk_watch #(.LIMIT(LOSS_CYCLES)) u_watch (
    .clk     (clk),
    .clr     (clr),
    .mark    (frame_mark),
    .loss_set(loss_set)
  );

  // Stage 1: collected word, plus a timer that releases it one frame later.
  always_ff @(posedge clk) begin
    if (clr) begin
      cap_q <= '0;
      tmr_q <= '0;
    end else if (ev.done) begin
      cap_q <= word_nxt;
      tmr_q <= TW'(BITS);
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - TW'(1);
    end
  end

  assign load   = (tmr_q == TW'(1));
  assign hold_n = loss_set || (hold_q && !load);
  assign ph_n   = (ph_q == TW'(BITS - 1)) ? '0 : ph_q + TW'(1);

  // Stage 2: output word, strobe phase and the lost-clock state.
  always_ff @(posedge clk) begin
    if (clr) begin
      data_out   <= '0;
      ph_q       <= '0;
      live_q     <= 1'b0;
      hold_q     <= 1'b0;
      strobe_out <= 1'b0;
    end else begin
      hold_q <= hold_n;
      if (load) begin
        data_out <= cap_q;
        ph_q     <= '0;
        live_q   <= 1'b1;
      end else begin
        ph_q <= ph_n;
      end
      if (hold_n)                strobe_out <= 1'b1;
      else if (load || !live_q)  strobe_out <= 1'b0;
      else                       strobe_out <= (ph_n >= TW'(LOW));
    end
  end
endmodule

// File: rtl/tl_deser_chk.sv
module tl_deser_chk #(
  parameter int WORD = 21
) (
  input logic            clk,
  input logic            rst,
  input logic            pwr_dn_n,
  input logic [WORD-1:0] data_out,
  input logic            strobe_out,
  input logic            hold_q
);
  assert_pd_low_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_dn_n) |-> (data_out == '0) && !strobe_out);

  assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (hold_q && $past(hold_q)) |-> strobe_out && $stable(data_out));

  assert_rise_stable_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_out) |-> $stable(data_out));

  assert_update_low_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr_dn_n) && (data_out != $past(data_out))) |-> !strobe_out);
endmodule

bind tl_deser tl_deser_chk #(.WORD(WORD)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwr_dn_n  (pwr_dn_n),
  .data_out  (data_out),
  .strobe_out(strobe_out),
  .hold_q    (hold_q)
);

// File: tb/tl_deser_tb.sv
module tl_deser_tb;
  localparam int LANES = 3;
  localparam int BITS  = 7;
  localparam int LIM   = 20;
  localparam int W     = LANES * BITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_dn_n = 1'b1;
  logic frame_mark = 1'b0;
  logic [LANES-1:0] ser_in = '0;
  logic [W-1:0] data_out;
  logic strobe_out;

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  int last_c0 = 0;
  logic [W-1:0] prev_w = '0;
  logic [W-1:0] exp_w[$];
  int exp_at[$];
  string exp_t[$];

  tl_deser #(.LANES(LANES), .BITS(BITS), .LOSS_CYCLES(LIM)) u_dut (
    .clk(clk), .rst(rst), .pwr_dn_n(pwr_dn_n), .frame_mark(frame_mark),
    .ser_in(ser_in), .data_out(data_out), .strobe_out(strobe_out));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", req, act, expv, cyc);
    end
  endtask

  // Word check on the edge it is due, previous word one edge earlier.
  always @(negedge clk) begin
    if (exp_at.size() > 0) begin
      if (cyc == exp_at[0] - 1)
        chk(data_out == prev_w, {exp_t[0], " R2 previous word"}, 32'(data_out), 32'(prev_w));
      if (cyc == exp_at[0]) begin
        chk(data_out == exp_w[0], {exp_t[0], " R1 R2 word"}, 32'(data_out), 32'(exp_w[0]));
        prev_w = exp_w[0];
        void'(exp_w.pop_front());
        void'(exp_at.pop_front());
        void'(exp_t.pop_front());
      end
    end
  end

  task automatic send_frame(input logic [W-1:0] w, input bit rec, input string tag);
    for (int k = 0; k < BITS; k++) begin
      @(negedge clk);
      if (k == 0) begin
        last_c0 = cyc;
        if (rec) begin
          exp_w.push_back(w);
          exp_at.push_back(cyc + 14);
          exp_t.push_back(tag);
        end
      end
      frame_mark = (k == 0);
      for (int l = 0; l < LANES; l++) ser_in[l] = w[l*BITS + k];
    end
  endtask

  task automatic idle_to(input int n);
    while (cyc < n) begin
      @(negedge clk);
      frame_mark = 1'b0;
      ser_in = LANES'($urandom);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int c;
    logic [W-1:0] w;
    repeat (4) @(negedge clk);
    chk(data_out == '0, "R9 reset data", 32'(data_out), 0);
    chk(strobe_out == 1'b0, "R9 reset strobe", 32'(strobe_out), 0);
    rst = 1'b0;

    // R1: walking one over every output bit, then random words (R2)
    for (int b = 0; b < W; b++) send_frame(W'(1) << b, 1'b1, "R1");
    for (int i = 0; i < 30; i++) send_frame(W'($urandom), 1'b1, "R2");
    // R6: lanes idle high with markers running
    for (int i = 0; i < 3; i++) send_frame('1, 1'b1, "R6");
    c = last_c0;

    // R3: strobe phase after the last load, then R7 loss
    for (int j = 0; j < BITS; j++) begin
      idle_to(c + 14 + j);
      chk(strobe_out == (j >= 3), "R3 strobe phase", 32'(strobe_out), 32'(j >= 3));
    end
    idle_to(c + 1 + LIM);
    chk(strobe_out == 1'b1, "R7 strobe high on loss", 32'(strobe_out), 1);
    chk(data_out == '1, "R7 data held", 32'(data_out), 32'(W'('1)));
    idle_to(c + 70);
    chk(strobe_out == 1'b1, "R7 strobe still high", 32'(strobe_out), 1);
    chk(data_out == '1, "R7 data still held", 32'(data_out), 32'(W'('1)));

    // R8: recovery on first complete frame
    w = W'(21'h0A5C3E);
    send_frame(w, 1'b1, "R8");
    c = last_c0;
    idle_to(c + 13);
    chk(strobe_out == 1'b1, "R8 strobe high before exit", 32'(strobe_out), 1);
    idle_to(c + 14);
    chk(strobe_out == 1'b0, "R8 strobe low at exit", 32'(strobe_out), 0);
    chk(data_out == w, "R8 new word at exit", 32'(data_out), 32'(w));
    idle_to(c + 16);

    // R4: power-down forcing
    @(negedge clk);
    pwr_dn_n = 1'b0;
    @(negedge clk);
    chk(data_out == '0, "R4 data forced low", 32'(data_out), 0);
    chk(strobe_out == 1'b0, "R4 strobe forced low", 32'(strobe_out), 0);
    for (int i = 0; i < 3; i++) begin
      send_frame(W'($urandom), 1'b0, "R4");
      chk(data_out == '0, "R4 data low during frames", 32'(data_out), 0);
      chk(strobe_out == 1'b0, "R4 strobe low during frames", 32'(strobe_out), 0);
    end

    // R5: frame straddling the release is dropped
    for (int k = 0; k < BITS; k++) begin
      @(negedge clk);
      frame_mark = (k == 0);
      ser_in = LANES'($urandom);
      if (k == 3) pwr_dn_n = 1'b1;
    end
    prev_w = '0;
    w = W'(21'h13579B);
    send_frame(w, 1'b1, "R5");
    c = last_c0;
    for (int j = 7; j <= 13; j++) begin
      idle_to(c + j);
      chk(strobe_out == 1'b0, "R5 strobe low until first word", 32'(strobe_out), 0);
      chk(data_out == '0, "R5 data low until first word", 32'(data_out), 0);
    end
    idle_to(c + 16);
    chk(exp_at.size() == 0, "R2 all words seen", 32'(exp_at.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule